// File: doc/BRIEF.md
# Reset Release Tree

This block turns one or more asynchronous reset requests into active-high resets for a single clock domain. The requests are ORed together. Any request presets a chain of flops at once, with no clock needed. When the last request goes away, a 0 is clocked through the chain, so the release edge is synchronous to the clock and has passed through enough stages to settle metastability.

After the chain comes one output pipeline flop. It sits outside the synchronizer, so it may be duplicated for fanout. A parameter sets its type: it is either preset asynchronously like the chain, or it is a plain register that delays assertion by one cycle.

The output then feeds a re-pipeline register in each major block, which splits the reset into sub-trees. In each block the tree reset is ORed with that block's own local reset before its register. Every block therefore leaves reset on the same clock edge, and a local reset affects only its own block.

Top module: `rst_release_tree`

## Requirements
- R1: When OUT_ASYNC is 1, raising any bit of rstReqAsync drives every bit of blockRst to 1 immediately, even while the clock is stopped.
- R2: After the last request bit falls, blockRst falls on exactly rising edge number SYNC_STAGES+2, counted from the first edge after the fall. Before that edge it stays 1.
- R3: Every block whose localRst is low leaves reset on the same rising edge.
- R4: When OUT_ASYNC is 0, a request does not touch blockRst while the clock is stopped. blockRst rises on the second rising edge after the request is seen, and the release latency is the same as in R2.
- R5: Once the tree is out of reset, localRst[i] at 1 on a rising edge sets only blockRst[i] to 1 from that edge on. It is cleared on the first edge on which localRst[i] is 0. All other bits stay 0.
- R6: A request pulse during a release restarts the release, and the full SYNC_STAGES+2 count begins again from the fall of that pulse.
- R7: blockRst stays 1 while any bit of rstReqAsync is 1, even after the other bits have fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Destination clock |
| rstReqAsync | input | NUM_REQ | Asynchronous reset requests, active high, ORed together |
| localRst | input | NUM_BLOCKS | Per-block local reset, synchronous, active high |
| blockRst | output | NUM_BLOCKS | Per-block registered reset, active high |

## Verification
The bench builds two instances that share the same inputs. Both use SYNC_STAGES=4, NUM_REQ=2 and NUM_BLOCKS=3. One instance has an asynchronously preset output stage and the other a plain pipeline output stage. The short chain keeps the exact release count and the restart-in-flight case to a few cycles. Side-by-side instances show the difference in assertion latency and in behaviour while the clock is stopped. Three blocks are enough to show that one local reset leaves the other blocks untouched.

// File: rtl/rst_release_pkg.sv
package rst_release_pkg;
  // Strobes from the synchronizer control to the per-block stages
  typedef struct packed {
    logic treeRst;    // registered output-stage reset
    logic presetNow;  // asynchronous preset for the block stages
  } relStrobe_t;
endpackage

// File: rtl/rst_sync_ctrl.sv
module rst_sync_ctrl
  import rst_release_pkg::*;
#(
  parameter int SYNC_STAGES = 7,
  parameter bit OUT_ASYNC   = 1'b1,
  parameter int NUM_REQ     = 2
) (
  input  logic               clk,
  input  logic [NUM_REQ-1:0] rstReqAsync,
  output relStrobe_t         strb
);
  localparam int CW = $clog2(SYNC_STAGES + 2) + 1;

  logic                   anyReq;
  logic [SYNC_STAGES-1:0] chainQ;
  logic                   chainLast;
  logic                   outQ;

  assign anyReq    = |rstReqAsync;
  assign chainLast = chainQ[SYNC_STAGES-1];

  // Synchronizer chain: preset on request, shift in 0 on each clock edge
  always_ff @(posedge clk or posedge anyReq) begin
    if (anyReq) chainQ <= '1;
    else        chainQ <= {chainQ[SYNC_STAGES-2:0], 1'b0};
  end

  // Output pipeline stage, one of two variants
  generate
    if (OUT_ASYNC) begin : g_outAsync
      always_ff @(posedge clk or posedge anyReq) begin
        if (anyReq) outQ <= 1'b1;
        else        outQ <= chainLast;
      end
    end else begin : g_outPipe
      always_ff @(posedge clk) outQ <= chainLast;
    end
  endgenerate

  assign strb.treeRst   = outQ;
  assign strb.presetNow = OUT_ASYNC ? anyReq : 1'b0;

  // Checker: counts the quiet edges since the last request
  logic [CW-1:0] quietCnt;
  always_ff @(posedge clk or posedge anyReq) begin
    if (anyReq) quietCnt <= '0;
    else if (quietCnt < CW'(SYNC_STAGES + 1)) quietCnt <= quietCnt + 1'b1;
  end

  p_release_count_r2: assert property (@(posedge clk) disable iff (anyReq)
    chainLast == (quietCnt < CW'(SYNC_STAGES)))
    else $error("R2: chain released at wrong count");
endmodule

// File: rtl/rst_block_stages.sv
module rst_block_stages
  import rst_release_pkg::*;
#(
  parameter int NUM_BLOCKS = 4
) (
  input  logic                  clk,
  input  relStrobe_t            strb,
  input  logic [NUM_BLOCKS-1:0] localRst,
  output logic [NUM_BLOCKS-1:0] blockRst
);
  logic presetNow;
  logic treeRst;
  assign presetNow = strb.presetNow;
  assign treeRst   = strb.treeRst;

  generate
    for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
      always_ff @(posedge clk or posedge presetNow) begin
        if (presetNow) blockRst[gi] <= 1'b1;
        else           blockRst[gi] <= treeRst | localRst[gi];
      end

      p_local_isolated_r5: assert property (@(posedge clk) disable iff (presetNow)
        (!$past(treeRst) && !$past(localRst[gi])) |-> !blockRst[gi])
        else $error("R5: block %0d held in reset without cause", gi);
    end
  endgenerate

  p_tree_covers_all_r3: assert property (@(posedge clk) disable iff (presetNow)
    $past(treeRst) |-> (&blockRst))
    else $error("R3: a block left reset early");

  p_async_assert_r1: assert property (@(posedge clk)
    presetNow |-> (&blockRst))
    else $error("R1: preset did not reach every block");
endmodule

// File: rtl/rst_release_tree.sv
module rst_release_tree
  import rst_release_pkg::*;
#(
  parameter int SYNC_STAGES = 7,
  parameter bit OUT_ASYNC   = 1'b1,
  parameter int NUM_REQ     = 2,
  parameter int NUM_BLOCKS  = 4
) (
  input  logic                  clk,
  input  logic [NUM_REQ-1:0]    rstReqAsync,
  input  logic [NUM_BLOCKS-1:0] localRst,
  output logic [NUM_BLOCKS-1:0] blockRst
);
  relStrobe_t strb;

  rst_sync_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .OUT_ASYNC  (OUT_ASYNC),
    .NUM_REQ    (NUM_REQ)
  ) u_ctrl (
    .clk        (clk),
    .rstReqAsync(rstReqAsync),
    .strb       (strb)
  );

  rst_block_stages #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_blocks (
    .clk     (clk),
    .strb    (strb),
    .localRst(localRst),
    .blockRst(blockRst)
  );
endmodule

// File: tb/rst_release_tree_tb.sv
module rst_release_tree_tb;
  localparam int S  = 4;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          clkEn = 1'b1;
  logic [1:0]    rstReq;
  logic [NB-1:0] localRst;
  logic [NB-1:0] rstA, rstP;
  int            nRun = 0, nFail = 0;
  bit            done = 1'b0;

  initial forever begin
    #4;
    if (clkEn) clk = ~clk;
  end

  rst_release_tree #(.SYNC_STAGES(S), .OUT_ASYNC(1'b1), .NUM_REQ(2), .NUM_BLOCKS(NB))
    u_dut (.clk(clk), .rstReqAsync(rstReq), .localRst(localRst), .blockRst(rstA));

  rst_release_tree #(.SYNC_STAGES(S), .OUT_ASYNC(1'b0), .NUM_REQ(2), .NUM_BLOCKS(NB))
    u_dutPipe (.clk(clk), .rstReqAsync(rstReq), .localRst(localRst), .blockRst(rstP));

  // {local pattern, expected blockRst}
  localparam logic [5:0] VECS [6] = '{
    {3'b001, 3'b001}, {3'b100, 3'b100}, {3'b000, 3'b000},
    {3'b011, 3'b011}, {3'b111, 3'b111}, {3'b000, 3'b000}
  };

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #160000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    rstReq = 2'b11;
    localRst = '0;
    edges(3);
    chk("R1 reset state async", rstA, 3'b111);
    chk("R4 reset state pipe", rstP, 3'b111);

    // R7: one request still high keeps the tree in reset
    rstReq = 2'b10;
    edges(S + 3);
    chk("R7 async", rstA, 3'b111);
    chk("R7 pipe", rstP, 3'b111);

    // R2/R3: exact release count, all blocks together
    rstReq = 2'b00;
    edges(S + 1);
    chk("R2 before release async", rstA, 3'b111);
    chk("R4 before release pipe", rstP, 3'b111);
    edges(1);
    chk("R2 R3 release async", rstA, 3'b000);
    chk("R4 R3 release pipe", rstP, 3'b000);

    // R5: local resets via table
    for (int i = 0; i < 6; i++) begin
      localRst = VECS[i][5:3];
      edges(1);
      chk("R5 local async", rstA, VECS[i][2:0]);
      chk("R5 local pipe", rstP, VECS[i][2:0]);
    end

    // R1/R4: request while the clock is stopped
    clkEn = 1'b0;
    #20 rstReq = 2'b10;
    #2;
    chk("R1 no clock async", rstA, 3'b111);
    chk("R4 no clock pipe", rstP, 3'b000);
    clkEn = 1'b1;
    edges(1);
    chk("R4 pipe first edge", rstP, 3'b000);
    edges(1);
    chk("R4 pipe second edge", rstP, 3'b111);

    rstReq = 2'b00;
    edges(S + 2);
    chk("R2 second release async", rstA, 3'b000);
    chk("R2 second release pipe", rstP, 3'b000);

    // R6: pulse during release restarts the count
    rstReq = 2'b01;
    edges(1);
    rstReq = 2'b00;
    edges(2);
    rstReq = 2'b01;
    edges(1);
    rstReq = 2'b00;
    edges(S + 1);
    chk("R6 restart hold async", rstA, 3'b111);
    chk("R6 restart hold pipe", rstP, 3'b111);
    edges(1);
    chk("R6 restart release async", rstA, 3'b000);
    chk("R6 restart release pipe", rstP, 3'b000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule